// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register with Clock Inhibit

This block is a parameterised chain of storage stages (eight by default) that either captures a parallel word or moves its contents one place toward a single serial output. A level-sensitive mode input selects between the two operations. While the mode input is low, the chain is transparent to the parallel word on every system clock. While it is high, the chain keeps its contents. It then advances by one stage for each qualified shift edge, and a serial input fills the first stage.

Shift edges do not come from the system clock. They come from two pins that are ORed together. The result is synchronised into the system clock domain and edge-detected. A rising edge of the OR counts as one shift. Holding either pin high masks any activity on the other pin. For this reason either pin can act as the shift clock while the other acts as an inhibit. Only the last stage is visible at the port. The other stages can be observed only by shifting them out.

Top module: `spl_piso_reg`

## Requirements
- R1: After reset every stage holds 0. `ser_out` reads 0, and shifting with `ser_in` low produces only zeros.
- R2: While `mode_shift` is 0, every stage takes its bit of `load_data` on each system clock. Bit STAGES-1 feeds the last stage, so `ser_out` shows `load_data[STAGES-1]` from the following clock.
- R3: While `mode_shift` is 0, `ser_in`, `ck_a` and `ck_b` have no effect on the stage contents.
- R4: While `mode_shift` is 1 and no shift edge occurs, the stages hold their values, and changes on `load_data` are ignored.
- R5: When `mode_shift` is 1, each qualified shift edge moves stage i into stage i+1 (stage STAGES-1 is the output) and loads `ser_in` into stage 0.
- R6: While `ck_b` is held high, transitions on `ck_a` cause no shift.
- R7: The roles of the pins swap: while `ck_a` is held high, transitions on `ck_b` cause no shift, and pulses on `ck_b` shift the chain.
- R8: A 1 entered at `ser_in` on one shift edge appears at `ser_out` on exactly the STAGES-th shift edge, counting that edge as the first.
- R9: After an alternating 1/0 word is loaded and shifted, `ser_out` toggles on each shift edge. After STAGES edges it shows only the `ser_in` level.
- R10: A rising edge of `ck_a | ck_b` produces exactly one shift, however long the pin stays high. The shift takes effect SYNC_STAGES+1 system clocks after the first clock that samples the pin high.
- R11: A shift edge that occurs while `mode_shift` is 0 is consumed. It causes no shift, even if the mode changes to shift while the pin is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_shift | input | 1 | 0 = load from parallel word, 1 = shift |
| ck_a | input | 1 | Shift clock / inhibit pin, ORed with ck_b |
| ck_b | input | 1 | Shift clock / inhibit pin, ORed with ck_a |
| load_data | input | STAGES | Parallel word, bit STAGES-1 feeds the output stage |
| ser_in | input | 1 | Serial data into the first stage |
| ser_out | output | 1 | Content of the last stage |

## Verification
Several different words are loaded and then shifted out. One is alternating. One is a single marching 1. Others have a 1/0 boundary near the output. Each word exposes a different fault: a reversed bit order, a missing serial fill, or an off-by-one in the chain length. Runs with one pin held high while the other is pulsed, done for each pin in turn, tell a correct OR qualification apart from a one-sided inhibit. A pin held high for many cycles, and an edge that arrives during load mode, tell edge detection apart from level sensitivity, and show whether load takes priority. A behavioural reference compares `ser_out` on every clock.

// File: rtl/spl_pkg.sv
package spl_pkg;
   typedef enum logic {
      MODE_LOAD  = 1'b0,
      MODE_SHIFT = 1'b1
   } spl_mode_e;

   localparam int unsigned SPL_MAX_SYNC = 4;
endpackage

// File: rtl/spl_clk_qual.sv
module spl_clk_qual #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_a,
   input  logic pin_b,
   output logic rise_o
);
   import spl_pkg::*;

   logic pin_or;
   logic level_s;
   logic level_d;

   assign pin_or = pin_a | pin_b;

   if (SYNC_STAGES > SPL_MAX_SYNC) begin : g_bad_sync
      $error("spl_clk_qual: SYNC_STAGES too large");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level_s = pin_or;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= pin_or;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sync_q[i] <= sync_q[i-1];
               end
            end
         end
         assign level_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level_s;
   end

   assign rise_o = level_s & ~level_d;

   // R10: one pulse per rising edge of the combined pins
   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/spl_mode_dec.sv
module spl_mode_dec (
   input  logic               mode_shift,
   input  logic               rise,
   output spl_pkg::spl_mode_e mode_o,
   output logic               shift_en_o
);
   import spl_pkg::*;

   always_comb begin
      mode_o     = mode_shift ? MODE_SHIFT : MODE_LOAD;
      shift_en_o = (mode_o == MODE_SHIFT) && rise;
   end
endmodule

// File: rtl/spl_stage_chain.sv
module spl_stage_chain #(
   parameter int unsigned STAGES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  spl_pkg::spl_mode_e mode,
   input  logic               shift_en,
   input  logic [STAGES-1:0]  par_d,
   input  logic               ser_d,
   output logic [STAGES-1:0]  stage_q
);
   import spl_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("spl_stage_chain: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic bit_q;
      logic shift_d;
      if (g == 0) begin : g_head
         assign shift_d = ser_d;
      end else begin : g_body
         assign shift_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 bit_q <= 1'b0;
         else if (mode == MODE_LOAD) bit_q <= par_d[g];
         else if (shift_en)          bit_q <= shift_d;
      end
      assign stage_q[g] = bit_q;
   end

   // R4: contents hold in shift mode without an edge
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SHIFT && !shift_en) |=> $stable(stage_q));

   // R5: the output stage receives its neighbour on a shift
   p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SHIFT && shift_en) |=> stage_q[LAST] == $past(stage_q[LAST-1]));

   // R5: the head stage receives the serial input on a shift
   p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SHIFT && shift_en) |=> stage_q[0] == $past(ser_d));
endmodule

// File: rtl/spl_piso_reg.sv
module spl_piso_reg #(
   parameter int unsigned STAGES      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_shift,
   input  logic              ck_a,
   input  logic              ck_b,
   input  logic [STAGES-1:0] load_data,
   input  logic              ser_in,
   output logic              ser_out
);
   import spl_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   logic              rise;
   spl_mode_e         mode;
   logic              shift_en;
   logic [STAGES-1:0] stage_q;

   spl_clk_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_a  (ck_a),
      .pin_b  (ck_b),
      .rise_o (rise)
   );

   spl_mode_dec u_mode (
      .mode_shift (mode_shift),
      .rise       (rise),
      .mode_o     (mode),
      .shift_en_o (shift_en)
   );

   spl_stage_chain #(.STAGES(STAGES)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .shift_en (shift_en),
      .par_d    (load_data),
      .ser_d    (ser_in),
      .stage_q  (stage_q)
   );

   assign ser_out = stage_q[LAST];

   // R2: output follows the top parallel bit in load mode
   p_load_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_shift |=> ser_out == $past(load_data[LAST]));

   // R11: no shift is enabled while loading
   p_load_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_shift |-> !shift_en);
endmodule

// File: tb/tb_spl_piso_reg.sv
module tb_spl_piso_reg;
   localparam int STAGES = 8;
   localparam int SYNC   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_shift = 1'b1;
   logic ck_a = 1'b0;
   logic ck_b = 1'b0;
   logic [STAGES-1:0] load_data = '0;
   logic ser_in = 1'b0;
   logic ser_out;

   int n_checks = 0;
   int n_fail = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   spl_piso_reg #(.STAGES(STAGES), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .mode_shift(mode_shift), .ck_a(ck_a), .ck_b(ck_b),
      .load_data(load_data), .ser_in(ser_in), .ser_out(ser_out)
   );

   // behavioural reference: pin history queue and a bit vector
   bit [STAGES-1:0] ref_q;
   bit hist[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q = '0;
         hist = {};
         for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
      end else begin
         bit edge_seen;
         edge_seen = hist[SYNC-1] && !hist[SYNC];
         if (!mode_shift) ref_q = load_data;
         else if (edge_seen) ref_q = {ref_q[STAGES-2:0], ser_in};
         hist.push_front(ck_a | ck_b);
         void'(hist.pop_back());
      end
   end

   task automatic check(string req, logic got, logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) check({cur_req, " model"}, ser_out, ref_q[STAGES-1]);
   end

   task automatic tick(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic pulse_a();
      ck_a = 1'b1; tick(3); ck_a = 1'b0; tick(3);
   endtask

   task automatic pulse_b();
      ck_b = 1'b1; tick(3); ck_b = 1'b0; tick(3);
   endtask

   task automatic load_word(logic [STAGES-1:0] w);
      mode_shift = 1'b0; load_data = w; tick(1); mode_shift = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [STAGES-1:0] alt;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      cur_req = "R1";
      check("R1", ser_out, 1'b0);
      for (int k = 0; k < STAGES; k++) begin
         pulse_a();
         check("R1", ser_out, 1'b0);
      end

      // R2 load mode transparency
      cur_req = "R2";
      mode_shift = 1'b0; load_data = 8'hA5; tick(1);
      check("R2", ser_out, 1'b1);
      load_data = 8'h5A; tick(1);
      check("R2", ser_out, 1'b0);

      // R3 serial input and pins ignored while loading
      cur_req = "R3";
      load_data = 8'h80; tick(1);
      ser_in = 1'b1; pulse_a(); ser_in = 1'b0; pulse_b();
      check("R3", ser_out, 1'b1);
      load_data = 8'h00; ck_a = 1'b1; tick(4);
      check("R3", ser_out, 1'b0);
      ck_a = 1'b0; tick(4);

      // R4 hold in shift mode, parallel word ignored
      cur_req = "R4";
      load_word(8'hC0);
      load_data = 8'h00; tick(4);
      check("R4", ser_out, 1'b1);
      pulse_a();
      check("R4", ser_out, 1'b1);

      // R9 alternating word, serial level fills
      cur_req = "R9";
      alt = 8'hAA; ser_in = 1'b1;
      load_word(alt);
      check("R9", ser_out, alt[STAGES-1]);
      for (int k = 1; k <= STAGES + 2; k++) begin
         pulse_a();
         check("R9", ser_out, (k < STAGES) ? alt[STAGES-1-k] : 1'b1);
      end
      alt = 8'h55; ser_in = 1'b0;
      load_word(alt);
      for (int k = 1; k <= STAGES + 1; k++) begin
         pulse_b();
         check("R9", ser_out, (k < STAGES) ? alt[STAGES-1-k] : 1'b0);
      end

      // R5 and R8 single marching one
      cur_req = "R8";
      load_word(8'h00);
      ser_in = 1'b1; pulse_a(); ser_in = 1'b0;
      for (int k = 2; k <= STAGES + 1; k++) begin
         pulse_a();
         check((k == STAGES) ? "R8" : "R5", ser_out, (k == STAGES) ? 1'b1 : 1'b0);
      end

      // R6 ck_b high inhibits ck_a
      cur_req = "R6";
      load_word(8'hBF);
      ck_b = 1'b1; tick(4);
      check("R6", ser_out, 1'b0);
      for (int k = 0; k < 5; k++) begin
         ck_a = 1'b1; tick(2); ck_a = 1'b0; tick(2);
      end
      check("R6", ser_out, 1'b0);
      ck_b = 1'b0; tick(3);
      pulse_a();
      check("R6", ser_out, 1'b1);

      // R7 roles swapped
      cur_req = "R7";
      load_word(8'hBF);
      ck_a = 1'b1; tick(4);
      check("R7", ser_out, 1'b0);
      for (int k = 0; k < 5; k++) begin
         ck_b = 1'b1; tick(2); ck_b = 1'b0; tick(2);
      end
      check("R7", ser_out, 1'b0);
      ck_a = 1'b0; tick(3);
      pulse_b();
      check("R7", ser_out, 1'b1);

      // R10 timing and one shift per edge
      cur_req = "R10";
      load_word(8'h40);
      tick(3);
      ck_a = 1'b1;
      tick(SYNC);
      check("R10", ser_out, 1'b0);
      tick(1);
      check("R10", ser_out, 1'b1);
      tick(8);
      check("R10", ser_out, 1'b1);
      ck_a = 1'b0; tick(4);

      // R11 edge during load is consumed
      cur_req = "R11";
      mode_shift = 1'b0; load_data = 8'h80; tick(1);
      ck_a = 1'b1; tick(5);
      mode_shift = 1'b1; load_data = 8'h00; tick(6);
      check("R11", ser_out, 1'b1);
      ck_a = 1'b0; tick(3);
      pulse_a();
      check("R11", ser_out, 1'b0);

      tick(2);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule